// File: doc/BRIEF.md
# Bus Access Test Register Block

This block is a memory-mapped slave that gives a host a known target for checking its own low-level bus accesses. The host writes a test number into a select register. It then reads back three things for that test: the access width to use, the byte offset inside the 4 KiB window to write, and the data value to write. The host performs that write. The block counts every incoming write that matches the selected test in size, position and value. The host can read the running count to confirm that its accesses arrived as intended.

The built-in tests are numbered 0, 1 and 2 with no gaps. Any higher number reports an unsupported width code, so a host can step upward through the numbers until it meets that code. A zero-terminated ASCII label for the selected test sits at the end of the header. It is meant for debugging.

The bus is a 32-bit synchronous register port. The byte address is word aligned, so its two low bits are ignored. Writes use per-byte enables. Reads always return a whole word.

Top module: `bus_test_regs`

## Requirements
- R1: After reset, test 0 is selected, the hit count is 0, and the label reads "test0": word 5 reads 0x00000030 and word 4 reads 0x74736574.
- R2: A write to word 0 with byte enable 0 set loads wdata[7:0] as the test number. A read of word 0 returns the width code in bits 15:8 and zero in bits 7:0 and 31:16.
- R3: The built-in tests are: test 0 is width 1, offset 0x100, data 0x5A; test 1 is width 2, offset 0x104, data 0xA55A; test 2 is width 4, offset 0x108, data 0xDEADBEEF. Every higher test number reads width 0xFF, offset 0 and data 0.
- R4: Word 1 (byte 4) returns the selected test's 32-bit offset and word 2 (byte 8) returns its 32-bit data. Both are little endian, with byte 0 of each field in bits 7:0.
- R5: On the clock edge that takes a test-select write, the hit count is cleared to 0.
- R6: The count rises by one for a write that meets all three conditions. The word address must equal offset/4. The byte enables must equal the width's lane mask (0x1, 0x3 or 0xF) shifted by offset[1:0]. The enabled data lanes must equal the test data, shifted by the same amount.
- R7: A write that differs in address, byte enables or enabled data does not change the count. While an unsupported test is selected, no write changes the count.
- R8: The count saturates at its all-ones value, which is 0xFFFFFFFF for a 32-bit counter. A narrower counter reads back zero-extended at word 3 (byte 12).
- R9: Starting at byte 16, the label is "test" followed by the selected number in decimal with no leading zeros, then zero bytes. For example, test 12 reads 0x00003231 in word 5.
- R10: Reads of words 6 and above return 0. Writes to words 1 to 5 change nothing, and neither does a write to word 0 without byte enable 0.
- R11: Read data appears on rdata on the first clock edge after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| be | input | 4 | Write byte enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
Every result is available one clock edge after its stimulus:
- A selection change shows in the descriptor words one edge after the select write.
- The count clear and each counted hit land on the same edge as their write.
- Read data is registered on the edge that samples rd_en.

The bench drives strobes for exactly one cycle from a falling edge and reads the result at the next falling edge. After any write, the follow-up read therefore sees state that is already settled. The saturation case is checked with the counter narrowed to 4 bits, so that it saturates within a few writes.

// File: rtl/bat_pkg.sv
package bat_pkg;

  localparam int NUM_BUILTIN = 3;
  localparam logic [7:0] WIDTH_NONE = 8'hFF;

  typedef struct packed {
    logic [7:0]  width;
    logic [31:0] offset;
    logic [31:0] data;
  } test_desc_t;

  function automatic test_desc_t lookup_test(input logic [7:0] num);
    test_desc_t d;
    d.width  = WIDTH_NONE;
    d.offset = 32'h0;
    d.data   = 32'h0;
    if (int'(num) < NUM_BUILTIN) begin
      d.width  = 8'd1 << num[1:0];
      d.offset = 32'h100 + {22'h0, num, 2'b00};
      case (num[1:0])
        2'd0:    d.data = 32'h0000005A;
        2'd1:    d.data = 32'h0000A55A;
        default: d.data = 32'hDEADBEEF;
      endcase
    end
    return d;
  endfunction

  // Decimal digits of the test number as ASCII, little-endian packed, no leading zeros.
  function automatic logic [31:0] label_digits(input logic [7:0] num);
    logic [7:0] h, t, o;
    h = 8'h30 + num / 8'd100;
    t = 8'h30 + (num / 8'd10) % 8'd10;
    o = 8'h30 + num % 8'd10;
    if (num >= 8'd100)     return {8'h00, o, t, h};
    else if (num >= 8'd10) return {16'h0000, o, t};
    else                   return {24'h000000, o};
  endfunction

endpackage

// File: rtl/bat_test_table.sv
module bat_test_table
  import bat_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel,
  output test_desc_t       desc,
  output logic [31:0]      label_lo,
  output logic [31:0]      label_hi
);
  localparam logic [31:0] LABEL_PREFIX = 32'h74736574; // "test", little endian

  always_comb begin
    desc     = lookup_test(8'(sel));
    label_lo = LABEL_PREFIX;
    label_hi = label_digits(8'(sel));
  end

  always_comb begin
    assert (desc.width == 8'd1 || desc.width == 8'd2 || desc.width == 8'd4 ||
            desc.width == WIDTH_NONE)
      else $error("assert_width_code_R3 failed");
  end
endmodule

// File: rtl/bat_hit_counter.sv
module bat_hit_counter
  import bat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ADDR_W-3:0] waddr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  test_desc_t        desc,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       supported;
  logic [3:0] lane_mask;
  logic [3:0] exp_be;
  logic [31:0] exp_data;
  logic [3:0] lane_ok;
  logic       addr_ok;
  logic       hit;

  always_comb begin
    supported = 1'b1;
    case (desc.width)
      8'd1:    lane_mask = 4'b0001;
      8'd2:    lane_mask = 4'b0011;
      8'd4:    lane_mask = 4'b1111;
      default: begin lane_mask = 4'b0000; supported = 1'b0; end
    endcase
    exp_be   = lane_mask << desc.offset[1:0];
    exp_data = desc.data << {desc.offset[1:0], 3'b000};
    addr_ok  = (waddr == desc.offset[ADDR_W-1:2]) && (desc.offset[31:ADDR_W] == '0);
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_ok[i] = !exp_be[i] || (wdata[8*i +: 8] == exp_data[8*i +: 8]);
  end

  assign hit = wr_en && supported && addr_ok && (be == exp_be) && (&lane_ok);

  always_ff @(posedge clk) begin
    if (rst || clear)                    count <= '0;
    else if (hit && count != CNT_MAX)    count <= count + 1'b1;
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == '0);
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (count == $past(count) || count == $past(count) + 1'b1));
  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (!clear && count == CNT_MAX) |=> count == CNT_MAX);
  assert_no_hit_unsupported_R7: assert property (@(posedge clk) disable iff (rst)
    (!clear && !supported) |=> $stable(count));
endmodule

// File: rtl/bat_read_port.sv
module bat_read_port
  import bat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-3:0] raddr,
  input  test_desc_t        desc,
  input  logic [CNT_W-1:0]  count,
  input  logic [31:0]       label_lo,
  input  logic [31:0]       label_hi,
  output logic [31:0]       rdata
);
  localparam int LAST_WORD = 5;

  logic [31:0] mux;

  always_comb begin
    case (raddr)
      (ADDR_W-2)'(0): mux = {16'h0000, desc.width, 8'h00};
      (ADDR_W-2)'(1): mux = desc.offset;
      (ADDR_W-2)'(2): mux = desc.data;
      (ADDR_W-2)'(3): mux = 32'(count);
      (ADDR_W-2)'(4): mux = label_lo;
      (ADDR_W-2)'(5): mux = label_hi;
      default:        mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 32'h0;
    else if (rd_en) rdata <= mux;
  end

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && raddr > (ADDR_W-2)'(LAST_WORD)) |=> rdata == 32'h0);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/bus_test_regs.sv
module bus_test_regs
  import bat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [SEL_W-1:0]  sel;
  logic              sel_wr;
  test_desc_t        desc;
  logic [31:0]       label_lo, label_hi;
  logic [CNT_W-1:0]  count;

  assign word   = addr[ADDR_W-1:2];
  assign sel_wr = wr_en && (word == '0) && be[0];

  always_ff @(posedge clk) begin
    if (rst)         sel <= '0;
    else if (sel_wr) sel <= wdata[SEL_W-1:0];
  end

  bat_test_table #(.SEL_W(SEL_W)) u_table (
    .sel(sel), .desc(desc), .label_lo(label_lo), .label_hi(label_hi)
  );

  bat_hit_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clear(sel_wr), .wr_en(wr_en), .waddr(word),
    .be(be), .wdata(wdata), .desc(desc), .count(count)
  );

  bat_read_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .raddr(word), .desc(desc),
    .count(count), .label_lo(label_lo), .label_hi(label_hi), .rdata(rdata)
  );

  assert_reset_sel_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel == '0 && count == '0));
  assert_ro_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_wr) |=> $stable(sel));
endmodule

// File: tb/bus_test_regs_test.sv
module bus_test_regs_test;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0]        be = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bus_test_regs #(.ADDR_W(ADDR_W), .SEL_W(8), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .be(be), .wdata(wdata), .rdata(rdata)
  );

  // {sel, width, offset, data, label word 5}
  localparam logic [111:0] VEC [6] = '{
    {8'h00, 8'h01, 32'h00000100, 32'h0000005A, 32'h00000030},
    {8'h01, 8'h02, 32'h00000104, 32'h0000A55A, 32'h00000031},
    {8'h02, 8'h04, 32'h00000108, 32'hDEADBEEF, 32'h00000032},
    {8'h03, 8'hFF, 32'h00000000, 32'h00000000, 32'h00000033},
    {8'h0C, 8'hFF, 32'h00000000, 32'h00000000, 32'h00003231},
    {8'hFF, 8'hFF, 32'h00000000, 32'h00000000, 32'h00353532}
  };

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [3:0] b,
                           input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_check(input string req, input logic [ADDR_W-1:0] a,
                            input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    read_check("R1 width", 12'h000, 32'h00000100);
    read_check("R1 count", 12'h00C, 32'h0);
    read_check("R1 label lo", 12'h010, 32'h74736574);
    read_check("R1 label hi", 12'h014, 32'h00000030);

    // Table walk: R2 R3 R4 R9
    for (int i = 0; i < 6; i++) begin
      bus_write(12'h000, 4'b0001, {24'hABCDEF, VEC[i][111:104]});
      read_check("R2 width word", 12'h000, {16'h0, VEC[i][103:96], 8'h00});
      read_check("R3 R4 offset", 12'h004, VEC[i][95:64]);
      read_check("R3 R4 data", 12'h008, VEC[i][63:32]);
      read_check("R9 label hi", 12'h014, VEC[i][31:0]);
      read_check("R9 label lo", 12'h010, 32'h74736574);
    end

    // R6 / R7 with test 0
    bus_write(12'h000, 4'b0001, 32'h0);
    bus_write(12'h100, 4'b0001, 32'hFFFFFF5A);
    read_check("R6 byte hit", 12'h00C, 32'd1);
    bus_write(12'h100, 4'b0001, 32'h0000005A);
    read_check("R6 second hit", 12'h00C, 32'd2);
    bus_write(12'h100, 4'b0011, 32'h0000005A);
    bus_write(12'h104, 4'b0001, 32'h0000005A);
    bus_write(12'h100, 4'b0001, 32'h0000005B);
    read_check("R7 mismatches ignored", 12'h00C, 32'd2);

    // R5 clear then test 1
    bus_write(12'h000, 4'b0001, 32'h1);
    read_check("R5 clear on select", 12'h00C, 32'd0);
    bus_write(12'h104, 4'b0011, 32'h1234A55A);
    read_check("R6 half hit", 12'h00C, 32'd1);
    bus_write(12'h104, 4'b0110, 32'h00A55A00);
    read_check("R7 be shifted", 12'h00C, 32'd1);

    // test 2
    bus_write(12'h000, 4'b0001, 32'h2);
    bus_write(12'h108, 4'b1111, 32'hDEADBEEF);
    read_check("R6 word hit", 12'h00C, 32'd1);
    bus_write(12'h108, 4'b1111, 32'hDEADBEEE);
    read_check("R7 data mismatch", 12'h00C, 32'd1);

    // unsupported test
    bus_write(12'h000, 4'b0001, 32'h3);
    bus_write(12'h100, 4'b0001, 32'h5A);
    bus_write(12'h000, 4'b0000, 32'h0);
    read_check("R7 unsupported no count", 12'h00C, 32'd0);

    // R8 saturation (4-bit counter)
    bus_write(12'h000, 4'b0001, 32'h0);
    for (int k = 0; k < 17; k++) bus_write(12'h100, 4'b0001, 32'h5A);
    read_check("R8 saturate", 12'h00C, 32'd15);

    // R10 read-only writes ignored
    bus_write(12'h004, 4'b1111, 32'h0);
    bus_write(12'h00C, 4'b1111, 32'h0);
    bus_write(12'h000, 4'b0010, 32'h0000FF00);
    read_check("R10 offset kept", 12'h004, 32'h00000100);
    read_check("R10 count kept", 12'h00C, 32'd15);
    read_check("R10 sel kept", 12'h000, 32'h00000100);
    read_check("R10 unused 0x18", 12'h018, 32'h0);
    read_check("R10 unused 0xFFC", 12'hFFC, 32'h0);

    // R11 hold
    read_check("R11 read", 12'h008, 32'h0000005A);
    held = rdata;
    @(negedge clk); addr = 12'h000;
    repeat (3) @(negedge clk);
    check("R11 hold", rdata, held);

    // R1 reset again
    bus_write(12'h000, 4'b0001, 32'h2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_check("R1 re-reset label", 12'h014, 32'h00000030);
    read_check("R1 re-reset count", 12'h00C, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule